// File: doc/BRIEF.md
# Output Strobe Sequencer with Early Acquisition Release

This block sits on the output side of a rule-based inference engine. A start pulse opens an elaboration phase for a configured number of results, from 1 to 16. For each result that the compute datapath reports, the block registers the 10-bit value and a 4-bit output identifier onto its output buses. It also raises a strobe for exactly one clock period. Both buses then keep their value until the next strobe, so a consumer can latch them on the falling edge of the strobe.

Two status flags frame the phase. The phase-active flag is high from the start pulse until the last result has been strobed out. The acquisition-ready flag drops as soon as the second-to-last strobe ends. Input capture for the next phase can therefore run while the final result is still being computed. A mode input must be low for a phase to open. The inference arithmetic is not part of this block. The bench models it as a stub with a longer first latency and a shorter latency for each later result. The intended master clock is 40 MHz.

Top module: `out_strobe_seq`

## Requirements
- R1: A synchronous reset drives strobe, phase-active, data bus and identifier bus to 0 and drives acquisition-ready to 1.
- R2: A start pulse sampled while phase-active is low and the mode input is low sets phase-active on that edge and latches the last-index field `cfg_last_i` (output count minus 1). The same edge sets acquisition-ready to 1 when the field is nonzero.
- R3: Each result-valid pulse sampled while phase-active is high makes the strobe high for exactly the following clock period. Valid pulses are at least two cycles apart.
- R4: The data bus takes the result value on the edge where the strobe rises and holds it unchanged until the next strobe.
- R5: The identifier bus updates on the strobe's rising edge, is 0 for the first result of a phase and counts up by one per result. It holds between strobes.
- R6: Acquisition-ready goes low on the edge where the strobe of result index `cfg_last_i`-1 falls. Before that edge it stays high.
- R7: With `cfg_last_i` = 0 (a single output), acquisition-ready goes low on the same edge that starts the phase.
- R8: Phase-active goes low on the edge where the strobe of result index `cfg_last_i` falls. While phase-active is low, result-valid pulses raise no strobe and leave both buses unchanged.
- R9: A start pulse while phase-active is high is ignored: the phase keeps its latched length and identifiers.
- R10: A start pulse while the mode input is high is ignored and phase-active stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Single-cycle request to open an elaboration phase |
| cfg_last_i | input | 4 | Number of outputs minus 1, latched at start |
| mode_i | input | 1 | Mode input, must be low for a phase to start |
| res_valid_i | input | 1 | Pulse marking a computed result |
| res_data_i | input | 10 | Computed result value |
| strobe_o | output | 1 | One-cycle strobe per delivered result |
| data_o | output | 10 | Held result value |
| id_o | output | 4 | Held output identifier |
| active_o | output | 1 | Elaboration phase in progress |
| acq_ready_o | output | 1 | Next input acquisition may begin |

## Verification
A wrong result counter shows up at the next strobe as an identifier out of sequence. It also moves the acquisition-ready and phase-active falling edges by whole results, and the bench sees that at the first strobe past the fault. A stuck or lost phase state shows within one cycle as a strobe outside a phase or a strobe that was missed. A capture enable that leaks shows as a data or identifier change between strobes, which the per-cycle hold checks catch on the cycle it happens.

// File: rtl/ose_pkg.sv
package ose_pkg;
    localparam int DEF_DATA_W = 10;
    localparam int DEF_ID_W   = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/ose_phase_ctrl.sv
module ose_phase_ctrl
    import ose_pkg::*;
#(
    parameter int ID_W = DEF_ID_W
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            start_i,
    input  logic            mode_i,
    input  logic [ID_W-1:0] cfg_last_i,
    input  logic            res_valid_i,
    input  logic            stb_q_i,
    input  logic [ID_W-1:0] id_q_i,
    output logic            take_o,
    output logic [ID_W-1:0] cnt_o,
    output logic            active_o,
    output logic            ready_o
);
    typedef struct packed {
        phase_e          ph;
        logic            rdy;
        logic [ID_W-1:0] last;
        logic [ID_W-1:0] cnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_q.ph == PH_IDLE) begin
            if (start_i && !mode_i) begin
                ctrl_d.ph   = PH_RUN;
                ctrl_d.last = cfg_last_i;
                ctrl_d.cnt  = '0;
                ctrl_d.rdy  = (cfg_last_i != '0);
            end
        end else begin
            if (res_valid_i) begin
                ctrl_d.cnt = ctrl_q.cnt + 1'b1;
            end
            if (stb_q_i && (ctrl_q.last != '0) && (id_q_i == ctrl_q.last - 1'b1)) begin
                ctrl_d.rdy = 1'b0;
            end
            if (stb_q_i && (id_q_i == ctrl_q.last)) begin
                ctrl_d.ph = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctrl_q.ph   <= PH_IDLE;
            ctrl_q.rdy  <= 1'b1;
            ctrl_q.last <= '0;
            ctrl_q.cnt  <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign take_o   = (ctrl_q.ph == PH_RUN) && res_valid_i;
    assign cnt_o    = ctrl_q.cnt;
    assign active_o = (ctrl_q.ph == PH_RUN);
    assign ready_o  = ctrl_q.rdy;
endmodule

// File: rtl/ose_out_stage.sv
module ose_out_stage
    import ose_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ID_W   = DEF_ID_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              take_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [ID_W-1:0]   cnt_i,
    output logic              stb_o,
    output logic [DATA_W-1:0] data_o,
    output logic [ID_W-1:0]   id_o
);
    typedef struct packed {
        logic              stb;
        logic [DATA_W-1:0] data;
        logic [ID_W-1:0]   id;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.stb = take_i;
        if (take_i) begin
            out_d.data = data_i;
            out_d.id   = cnt_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign stb_o  = out_q.stb;
    assign data_o = out_q.data;
    assign id_o   = out_q.id;
endmodule

// File: rtl/out_strobe_seq.sv
module out_strobe_seq
    import ose_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ID_W   = DEF_ID_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [ID_W-1:0]   cfg_last_i,
    input  logic              mode_i,
    input  logic              res_valid_i,
    input  logic [DATA_W-1:0] res_data_i,
    output logic              strobe_o,
    output logic [DATA_W-1:0] data_o,
    output logic [ID_W-1:0]   id_o,
    output logic              active_o,
    output logic              acq_ready_o
);
    logic            take;
    logic [ID_W-1:0] cnt;

    ose_phase_ctrl #(.ID_W(ID_W)) u_ctrl (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .cfg_last_i (cfg_last_i),
        .res_valid_i(res_valid_i),
        .stb_q_i    (strobe_o),
        .id_q_i     (id_o),
        .take_o     (take),
        .cnt_o      (cnt),
        .active_o   (active_o),
        .ready_o    (acq_ready_o)
    );

    ose_out_stage #(.DATA_W(DATA_W), .ID_W(ID_W)) u_out (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .take_i(take),
        .data_i(res_data_i),
        .cnt_i (cnt),
        .stb_o (strobe_o),
        .data_o(data_o),
        .id_o  (id_o)
    );
endmodule

// File: rtl/ose_checker.sv
module ose_checker #(
    parameter int DATA_W = 10,
    parameter int ID_W   = 4
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              start_i,
    input logic              mode_i,
    input logic              strobe_o,
    input logic [DATA_W-1:0] data_o,
    input logic [ID_W-1:0]   id_o,
    input logic              active_o,
    input logic              acq_ready_o
);
    AST_STB_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |=> !strobe_o); // R3
    AST_STB_IN_PHASE: assert property (@(posedge clk_i) disable iff (rst_i)
        strobe_o |-> $past(active_o)); // R3
    AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !strobe_o |-> ($stable(data_o) && $stable(id_o))); // R4
    AST_EP_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(active_o) |-> $past(strobe_o)); // R8
    AST_NP_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(acq_ready_o) |-> ($past(strobe_o) || $past(start_i))); // R6
    AST_MODE_BLOCK: assert property (@(posedge clk_i) disable iff (rst_i)
        (!active_o && mode_i) |=> !active_o); // R10
endmodule

bind out_strobe_seq ose_checker #(.DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .strobe_o   (strobe_o),
    .data_o     (data_o),
    .id_o       (id_o),
    .active_o   (active_o),
    .acq_ready_o(acq_ready_o)
);

// File: tb/test_out_strobe_seq.sv
`timescale 1ns/1ps
module test_out_strobe_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [3:0] cfg_last;
    logic       mode;
    logic       valid;
    logic [9:0] rdata;
    logic       strobe;
    logic [9:0] data;
    logic [3:0] id;
    logic       active;
    logic       ready;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    out_strobe_seq i_out_strobe_seq (
        .clk_i(clk), .rst_i(rst), .start_i(start), .cfg_last_i(cfg_last),
        .mode_i(mode), .res_valid_i(valid), .res_data_i(rdata),
        .strobe_o(strobe), .data_o(data), .id_o(id),
        .active_o(active), .acq_ready_o(ready)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Acquisition-ready while waiting for or showing result k (R6, R7)
    function automatic bit exp_ready_before(int last, int k);
        return (last != 0) && (k < last);
    endfunction

    // Acquisition-ready after strobe k has fallen (R6)
    function automatic bit exp_ready_after(int last, int k);
        return (last != 0) && (k + 1 < last);
    endfunction

    task automatic run_phase(input int last, input int lat1, input int latn, input bit inject);
        logic [9:0] held_d;
        logic [3:0] held_i;
        @(negedge clk);
        start = 1'b1; cfg_last = 4'(last);
        @(negedge clk);
        start = 1'b0; cfg_last = 4'($urandom);
        check("R2 phase-active after start", int'(active), 1);
        check("R2/R7 ready after start", int'(ready), int'(exp_ready_before(last, 0)));
        held_d = data; held_i = id;
        for (int k = 0; k <= last; k++) begin
            int lat;
            lat = (k == 0) ? lat1 : latn;
            for (int c = 0; c < lat; c++) begin
                if (inject && k == 1 && c == 1) start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R4 data hold", int'(data), int'(held_d));
                check("R5 id hold", int'(id), int'(held_i));
                check("R9 active during phase", int'(active), 1);
                check("R6 ready while waiting", int'(ready), int'(exp_ready_before(last, k)));
            end
            valid = 1'b1; rdata = 10'($urandom);
            held_d = rdata; held_i = 4'(k);
            @(negedge clk);
            valid = 1'b0;
            check("R3 strobe high", int'(strobe), 1);
            check("R4 data captured", int'(data), int'(held_d));
            check("R5 id value", int'(id), k);
            check("R6 ready at strobe", int'(ready), int'(exp_ready_before(last, k)));
            @(negedge clk);
            check("R3 strobe one cycle", int'(strobe), 0);
            check("R8 active after strobe", int'(active), int'(k != last));
            check("R6 ready after strobe", int'(ready), int'(exp_ready_after(last, k)));
        end
        // R8: valid outside a phase is ignored
        repeat (2) @(negedge clk);
        valid = 1'b1; rdata = ~held_d;
        @(negedge clk);
        valid = 1'b0;
        check("R8 no strobe when idle", int'(strobe), 0);
        check("R8 data unchanged when idle", int'(data), int'(held_d));
        check("R8 id unchanged when idle", int'(id), int'(held_i));
        check("R8 ready stays low when idle", int'(ready), 0);
    endtask

    task automatic check_reset_state();
        check("R1 strobe", int'(strobe), 0);
        check("R1 active", int'(active), 0);
        check("R1 data", int'(data), 0);
        check("R1 id", int'(id), 0);
        check("R1 ready", int'(ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1'b1; start = 1'b0; cfg_last = '0; mode = 1'b0; valid = 1'b0; rdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        // R10: mode high blocks start
        mode = 1'b1; start = 1'b1; cfg_last = 4'd3;
        @(negedge clk);
        start = 1'b0;
        check("R10 start blocked by mode", int'(active), 0);
        mode = 1'b0;

        run_phase(0, 24, 12, 1'b0);   // R7 single output
        run_phase(1, 24, 12, 1'b0);
        run_phase(15, 24, 12, 1'b1);  // R9 start injected mid-phase
        for (int p = 0; p < 6; p++) begin
            run_phase(int'($urandom % 16), 2 + int'($urandom % 29), 2 + int'($urandom % 15), p[0]);
        end

        // R1: reset in the middle of a phase
        @(negedge clk);
        start = 1'b1; cfg_last = 4'd5;
        @(negedge clk);
        start = 1'b0;
        valid = 1'b1; rdata = 10'h2a5;
        @(negedge clk);
        valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule